// File: doc/BRIEF.md
# Preset-Timer Gated Decimal Pulse Scaler

This block counts the rising edges of an asynchronous detector pulse stream while a timed gate is open, then freezes the total as a multi-digit BCD value. The gate length is selected by two inputs. A decade range picks an interval of 1, 10, 100, 1000, 10000 or 100000 base units. A binary multiplier of 1, 2, 4 or 8 says how many of those intervals the gate lasts. The base unit is one millisecond of system clock, set by a parameter.

A start request from the idle state does three things: it clears the previous result, it presets a BCD down-counter with the multiplier, and it restarts a decade time base. Each interval tick from that time base decrements the down-counter. When the counter reaches zero the gate closes and the done flag is raised. The result then stays stable until the next start or clear. A count that would pass the largest representable value saturates and sets a sticky overflow flag.

Top module: `gated_bcd_scaler`

## Requirements
- R1: While the gate is open, each rising edge of `pulse_in` adds one to `count_bcd`. `count_bcd` holds DIGITS BCD digits: digit i sits in bits [4i+3:4i], each digit stays within 0..9, and carries follow decimal rules.
- R2: The gate stays open (`busy` = 1) for exactly M × 10^R × CYCLES_PER_UNIT clock cycles after the edge that accepts start. R is `range_sel` (0..5). M is 1, 2, 4 or 8 for `mult_sel` = 0, 1, 2 or 3.
- R3: A `range_sel` value of 6 or 7 gives the same gate length as 5.
- R4: When `busy` is low, a start accepted at a clock edge does four things at that edge: it zeroes `count_bcd`, it clears `done` and `overflow`, and it raises `busy`.
- R5: While `busy` is high, `start` is ignored: the gate neither restarts nor lengthens.
- R6: `done` rises at the same edge at which `busy` falls. It stays high until the next start or clear. While `done` is high, `count_bcd` stays frozen and pulses have no effect on it.
- R7: A pulse arriving when every digit is 9 leaves `count_bcd` at all nines and sets `overflow`. `overflow` stays set until a start or a clear.
- R8: `clear` is synchronous and has priority over `start`. At the next edge it zeroes `count_bcd` and forces `busy`, `done` and `overflow` low, which aborts any gate in progress.
- R9: After reset, `count_bcd` is zero and `busy`, `done` and `overflow` are low.
- R10: `pulse_in` is synchronized by two flops. A rising edge first shows in `count_bcd` at the third clock edge after the input rises. Pulses that are high and low for at least two clock periods each are counted one for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous detector pulse |
| start | input | 1 | Start a measurement from idle |
| clear | input | 1 | Synchronous clear of result and gate |
| range_sel | input | 3 | Decade range of the gate interval |
| mult_sel | input | 2 | Interval multiplier select (1, 2, 4, 8) |
| count_bcd | output | 4*DIGITS | Accumulated pulse count in BCD |
| busy | output | 1 | Gate open |
| done | output | 1 | Measurement finished, result frozen |
| overflow | output | 1 | Count saturated (sticky) |

## Verification
Every control result (`busy`, `done`, `overflow`, a zeroed count after start or clear) appears one edge after the stimulus that causes it. The bench drives inputs on falling edges and reads results at the following falling edge. A pulse is due in the count three edges after it rises, so the latency check samples at exactly the second and third falling edges after the input rise. Gate length is measured by counting falling edges with `busy` high until `done` appears. The final count is read a few cycles after that, once the last synchronized pulse has settled.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

    localparam int NUM_RANGES = 6;
    localparam logic [2:0] TOP_RANGE = 3'(NUM_RANGES - 1);

    typedef logic [3:0] bcd_digit_t;

    typedef struct packed {
        logic       busy;
        logic       done;
        logic       ovf;
        logic [2:0] rng;
    } ctrl_t;

    function automatic bcd_digit_t mult_preset(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            2'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [2:0] clamp_range(input logic [2:0] sel);
        return (sel > TOP_RANGE) ? TOP_RANGE : sel;
    endfunction

endpackage

// File: rtl/scaler_pulse_sync.sv
module scaler_pulse_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic rise
);
    logic [1:0] sync_d, sync_q;
    logic       prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[0], pulse_in};
        prev_d = sync_q[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise = sync_q[1] & ~prev_q;

    // R10: a detected edge lasts exactly one cycle
    assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/scaler_timebase.sv
module scaler_timebase #(
    parameter int CYCLES_PER_UNIT = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [2:0] range_sel,
    output logic       tick
);
    import scaler_pkg::*;

    localparam int BW      = (CYCLES_PER_UNIT > 1) ? $clog2(CYCLES_PER_UNIT) : 1;
    localparam int DECADES = NUM_RANGES - 1;

    logic [BW-1:0]    base_d, base_q;
    bcd_digit_t       dec_d [DECADES];
    bcd_digit_t       dec_q [DECADES];
    logic [DECADES:0] carry;

    assign carry[0] = run && (base_q == BW'(CYCLES_PER_UNIT - 1));

    always_comb begin
        if (restart)      base_d = '0;
        else if (carry[0]) base_d = '0;
        else if (run)     base_d = base_q + 1'b1;
        else              base_d = base_q;
    end

    for (genvar j = 0; j < DECADES; j++) begin : g_dec
        assign carry[j+1] = carry[j] && (dec_q[j] == 4'd9);
        always_comb begin
            if (restart)       dec_d[j] = '0;
            else if (carry[j]) dec_d[j] = (dec_q[j] == 4'd9) ? 4'd0 : dec_q[j] + 4'd1;
            else               dec_d[j] = dec_q[j];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dec_q[j] <= '0;
            else        dec_q[j] <= dec_d[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign tick = carry[clamp_range(range_sel)];

    // R2: an interval tick only occurs on a base-unit boundary of a running gate
    assert_tick_on_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (run && carry[0]));
endmodule

// File: rtl/scaler_bcd_counter.sv
module scaler_bcd_counter #(
    parameter int DIGITS   = 7,
    parameter bit COUNT_UP = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [4*DIGITS-1:0] load_val,
    input  logic                step,
    output logic [4*DIGITS-1:0] value,
    output logic                extreme
);
    localparam logic [3:0] EDGE_DIGIT = COUNT_UP ? 4'd9 : 4'd0;
    localparam logic [3:0] WRAP_DIGIT = COUNT_UP ? 4'd0 : 4'd9;

    logic [4*DIGITS-1:0] val_d, val_q;
    logic [DIGITS:0]     ripple;
    logic [DIGITS-1:0]   at_edge;

    assign ripple[0] = step;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] cur;
        assign cur        = val_q[4*i +: 4];
        assign at_edge[i] = (cur == EDGE_DIGIT);
        assign ripple[i+1] = ripple[i] && at_edge[i];
        always_comb begin
            if (load)           val_d[4*i +: 4] = load_val[4*i +: 4];
            else if (ripple[i]) val_d[4*i +: 4] = at_edge[i] ? WRAP_DIGIT :
                                                  (COUNT_UP ? cur + 4'd1 : cur - 4'd1);
            else                val_d[4*i +: 4] = cur;
        end

        // R1: every digit stays a valid decimal digit
        assert_digit_bcd_R1: assert property (@(posedge clk) disable iff (!rst_n)
            cur <= 4'd9);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value   = val_q;
    assign extreme = &at_edge;

    // R1: a step without load always moves the value
    assert_step_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (value != $past(value)));
endmodule

// File: rtl/gated_bcd_scaler.sv
module gated_bcd_scaler #(
    parameter int DIGITS          = 7,
    parameter int CYCLES_PER_UNIT = 20000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pulse_in,
    input  logic                start,
    input  logic                clear,
    input  logic [2:0]          range_sel,
    input  logic [1:0]          mult_sel,
    output logic [4*DIGITS-1:0] count_bcd,
    output logic                busy,
    output logic                done,
    output logic                overflow
);
    import scaler_pkg::*;

    localparam int W = 4 * DIGITS;

    ctrl_t        ctrl_d, ctrl_q;
    logic         rise, tick;
    logic         cnt_load, cnt_step, cnt_full;
    logic         tmr_load, tmr_step, tmr_zero;
    logic         tb_restart;
    logic [W-1:0] tmr_preset, tmr_val;

    scaler_pulse_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .rise(rise)
    );

    scaler_timebase #(.CYCLES_PER_UNIT(CYCLES_PER_UNIT)) u_tb (
        .clk(clk), .rst_n(rst_n), .restart(tb_restart), .run(ctrl_q.busy),
        .range_sel(ctrl_q.rng), .tick(tick)
    );

    scaler_bcd_counter #(.DIGITS(DIGITS), .COUNT_UP(1'b1)) u_count (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val('0),
        .step(cnt_step), .value(count_bcd), .extreme(cnt_full)
    );

    scaler_bcd_counter #(.DIGITS(DIGITS), .COUNT_UP(1'b0)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_preset),
        .step(tmr_step), .value(tmr_val), .extreme(tmr_zero)
    );

    always_comb begin
        ctrl_d     = ctrl_q;
        cnt_load   = 1'b0;
        cnt_step   = 1'b0;
        tmr_load   = 1'b0;
        tmr_step   = 1'b0;
        tb_restart = 1'b0;
        tmr_preset = {{(W-4){1'b0}}, mult_preset(mult_sel)};
        if (clear) begin
            ctrl_d     = '0;
            cnt_load   = 1'b1;
            tmr_load   = 1'b1;
            tmr_preset = '0;
            tb_restart = 1'b1;
        end else if (start && !ctrl_q.busy) begin
            ctrl_d.busy = 1'b1;
            ctrl_d.done = 1'b0;
            ctrl_d.ovf  = 1'b0;
            ctrl_d.rng  = clamp_range(range_sel);
            cnt_load    = 1'b1;
            tmr_load    = 1'b1;
            tb_restart  = 1'b1;
        end else if (ctrl_q.busy) begin
            if (rise) begin
                if (cnt_full) ctrl_d.ovf = 1'b1;
                else          cnt_step   = 1'b1;
            end
            if (tick) begin
                tmr_step = 1'b1;
                if (tmr_val == W'(1)) begin
                    ctrl_d.busy = 1'b0;
                    ctrl_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign busy     = ctrl_q.busy;
    assign done     = ctrl_q.done;
    assign overflow = ctrl_q.ovf;

    // R6: done and busy are never high together
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
    // R6: the frozen result does not move while done is held
    assert_result_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !clear) |=> $stable(count_bcd));
    // R7: overflow is sticky until start or clear
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear && !start) |=> overflow);
    // R8: clear returns the block to idle with an empty count
    assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!busy && !done && !overflow && count_bcd == '0));
    // R5: start during a gate cannot re-zero the count
    assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !clear && !tmr_zero) |=> (count_bcd >= $past(count_bcd)));
    // R2: the gate timer is never empty while the gate is open
    assert_timer_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tmr_zero);
endmodule

// File: tb/gated_bcd_scaler_test.sv
module gated_bcd_scaler_test;

    localparam int D  = 7;
    localparam int W  = 4 * D;
    localparam int DS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_in = 1'b0, start = 1'b0, clear = 1'b0;
    logic [2:0] range_sel = '0;
    logic [1:0] mult_sel = '0;
    logic [W-1:0] count_bcd;
    logic busy, done, overflow;

    logic s_pulse = 1'b0, s_start = 1'b0, s_clear = 1'b0;
    logic [4*DS-1:0] s_count;
    logic s_busy, s_done, s_ovf;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gated_bcd_scaler #(.DIGITS(D), .CYCLES_PER_UNIT(1)) uut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .start(start), .clear(clear),
        .range_sel(range_sel), .mult_sel(mult_sel), .count_bcd(count_bcd),
        .busy(busy), .done(done), .overflow(overflow)
    );

    gated_bcd_scaler #(.DIGITS(DS), .CYCLES_PER_UNIT(1)) uut_small (
        .clk(clk), .rst_n(rst_n), .pulse_in(s_pulse), .start(s_start), .clear(s_clear),
        .range_sel(3'd3), .mult_sel(2'd0), .count_bcd(s_count),
        .busy(s_busy), .done(s_done), .overflow(s_ovf)
    );

    typedef struct packed {
        logic [2:0] rng;
        logic [1:0] mul;
        int         npulse;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{rng: 3'd0, mul: 2'd0, npulse: 0},
        '{rng: 3'd0, mul: 2'd3, npulse: 0},
        '{rng: 3'd1, mul: 2'd1, npulse: 3},
        '{rng: 3'd2, mul: 2'd0, npulse: 12},
        '{rng: 3'd2, mul: 2'd2, npulse: 25},
        '{rng: 3'd1, mul: 2'd3, npulse: 19},
        '{rng: 3'd3, mul: 2'd0, npulse: 123}
    };

    function automatic logic [63:0] to_bcd(input int v);
        logic [63:0] r = '0;
        int x = v;
        for (int i = 0; i < 16; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic int gate_len(input int r, input int m);
        int n = 1 << m;
        int rr = (r > 5) ? 5 : r;
        for (int i = 0; i < rr; i++) n = n * 10;
        return n;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            pulse_in = 1'b1;
            repeat (2) @(negedge clk);
            pulse_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // start a gate, send pulses, measure busy length; returns measured length
    task automatic run_gate(input logic [2:0] r, input logic [1:0] m, input int n,
                            output int measured);
        int cyc = 0;
        @(negedge clk);
        range_sel = r; mult_sel = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            send_pulses(n);
            begin
                while (!done && cyc < 150000) begin
                    if (busy) cyc++;
                    @(negedge clk);
                end
            end
        join
        measured = cyc;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 count", 64'(count_bcd), 64'd0);
        chk("R9 flags", {busy, done, overflow}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: table of gate settings and pulse counts
        foreach (VECS[i]) begin
            run_gate(VECS[i].rng, VECS[i].mul, VECS[i].npulse, len);
            chk("R2 gate length", 64'(len), 64'(gate_len(VECS[i].rng, VECS[i].mul)));
            chk("R1 count", 64'(count_bcd), to_bcd(VECS[i].npulse));
            chk("R6 done/busy", {done, busy}, 2'b10);
        end

        // R6: pulses after the gate leave the frozen result alone
        send_pulses(5);
        repeat (4) @(negedge clk);
        chk("R6 frozen count", 64'(count_bcd), to_bcd(123));
        chk("R6 done held", done, 1'b1);

        // R2: higher decade range
        run_gate(3'd4, 2'd1, 0, len);
        chk("R2 range 4 x2", 64'(len), 64'd20000);

        // R3: out-of-range select behaves as the top range
        run_gate(3'd6, 2'd0, 0, len);
        chk("R3 clamp", 64'(len), 64'd100000);

        // R4: start from idle clears count and done, raises busy
        @(negedge clk);
        range_sel = 3'd2; mult_sel = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R4 start state", {busy, done, overflow}, 3'b100);
        chk("R4 count zero", 64'(count_bcd), 64'd0);

        // R10: latency from pulse rise to count
        pulse_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 not yet", 64'(count_bcd), 64'd0);
        @(negedge clk);
        chk("R10 due", 64'(count_bcd), 64'd1);
        pulse_in = 1'b0;

        // R5: a start mid-gate does not restart the gate (gate was 100 cycles)
        repeat (40) @(negedge clk);
        range_sel = 3'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R5 count kept", 64'(count_bcd), 64'd1);
        repeat (60) @(negedge clk);
        chk("R5 gate ended on time", {done, busy}, 2'b10);

        // R8: clear aborts a running gate
        @(negedge clk);
        range_sel = 3'd3; mult_sel = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        send_pulses(4);
        repeat (3) @(negedge clk);
        chk("R8 pre-clear count", 64'(count_bcd), 64'd4);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk("R8 cleared flags", {busy, done, overflow}, 3'b000);
        chk("R8 cleared count", 64'(count_bcd), 64'd0);
        // R8: clear wins over start
        clear = 1'b1; start = 1'b1;
        @(negedge clk);
        clear = 1'b0; start = 1'b0;
        chk("R8 priority", busy, 1'b0);

        // R7: saturation on the two-digit instance
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        for (int k = 0; k < 105; k++) begin
            s_pulse = 1'b1;
            repeat (2) @(negedge clk);
            s_pulse = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R7 saturated", 64'(s_count), 64'h99);
        chk("R7 overflow set", s_ovf, 1'b1);
        while (s_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R7 overflow sticky", s_ovf, 1'b1);
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        chk("R7 overflow cleared by start", {s_ovf, s_busy}, 2'b01);
        chk("R7 count cleared", 64'(s_count), 64'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule